// File: doc/BRIEF.md
# Three-Operand Integer Adder

This unit sums three 32-bit integer operands and returns one registered 32-bit result with condition flags. The operands arrive already fetched. Before the sum, each operand can be narrowed to one of its 16-bit halves and negated. The second operand can be replaced by a sign-extended 20-bit immediate.

A mode input selects how the first two operands are combined before the third is added. The plain mode adds all three. The right-shift mode forms the first pair's sum at 33 bits, so the pair's carry-out is kept, and shifts it down by 16. The left-shift mode moves the 32-bit pair sum up by 16.

An extend control feeds the stored carry flag into the final addition, so wider sums can be chained over several operations. A flag-update control decides whether an operation writes the zero, sign, carry and overflow flags.

Top module: `tri_add_unit`

## Requirements
- R1: With mode code 00 or 11, the result is A + B + C + cin, modulo 2^32.
- R2: With mode code 01, the result is (({1'b0,A} + {1'b0,B}) >> 16) + C + cin. The 33-bit pair carry lands in result bit 16.
- R3: With mode code 10, the result is (((A + B) mod 2^32) << 16) + C + cin, modulo 2^32.
- R4: Each operand has a half code: 00 or 11 passes the full 32 bits, 01 selects bits 15:0 and 10 selects bits 31:16, zero-extended in both cases. The half code is applied before negation.
- R5: When an operand's negate control is 1, that operand is replaced by its two's complement, after half selection.
- R6: When the immediate select is 1, operand B is the 20-bit immediate sign-extended to 32 bits, and B's register value and half code have no effect.
- R7: When the extend control is 1, cin is the carry flag held before the operation. Otherwise cin is 0.
- R8: When valid and flag-update are both 1, the flags are written one cycle later from the final addition M + C + cin, where M is the shifted pair sum. Zero is result == 0, sign is result bit 31, carry is bit 32 of the 33-bit final sum, and overflow is set when M and C share a sign that differs from the result's sign.
- R9: When valid or flag-update is 0, all four flags keep their values.
- R10: valid_o is valid_i delayed by one cycle. res_o changes only in the cycle after valid_i is 1.
- R11: While reset is asserted, res_o, valid_o and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are sampled this cycle |
| mode_i | input | 2 | 00 plain, 01 right shift, 10 left shift, 11 plain |
| a_i | input | 32 | Operand A |
| a_half_i | input | 2 | Half code for A |
| a_neg_i | input | 1 | Negate A |
| b_i | input | 32 | Operand B register value |
| b_half_i | input | 2 | Half code for B |
| b_neg_i | input | 1 | Negate B |
| b_imm_sel_i | input | 1 | Use the immediate as B |
| b_imm_i | input | 20 | Signed immediate for B |
| c_i | input | 32 | Operand C |
| c_half_i | input | 2 | Half code for C |
| c_neg_i | input | 1 | Negate C |
| ext_i | input | 1 | Feed the stored carry into the final add |
| cc_i | input | 1 | Write the flags |
| res_o | output | 32 | Registered result |
| valid_o | output | 1 | Result valid |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle valid latency;
- that the result holds when nothing is sampled;
- that the flags hold when no update is requested;
- that the zero and sign flags agree with the written result;
- two shape properties of the shift modes: the left-shift result's low half is operand C, and the right-shift result has no bits above 16 when C is zero.

Only the bench's sweeps can show the following:
- the full arithmetic of each mode;
- the ordering of half selection before negation;
- the immediate path;
- the carry and overflow values;
- carry chaining through the extend control.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN     = 2'b00,
    MODE_RSH       = 2'b01,
    MODE_LSH       = 2'b10,
    MODE_PLAIN_ALT = 2'b11
  } sum_mode_e;

  typedef enum logic [1:0] {
    HALF_FULL     = 2'b00,
    HALF_LO       = 2'b01,
    HALF_HI       = 2'b10,
    HALF_FULL_ALT = 2'b11
  } half_sel_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } flags_t;

endpackage

// File: rtl/tri_add_opsel.sv
module tri_add_opsel
  import tri_add_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 20,
  parameter bit HAS_IMM = 1'b0
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [1:0]        half_i,
  input  logic              neg_i,
  input  logic              imm_sel_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] op_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] reg_sel;
  logic [DATA_W-1:0] src_sel;

  always_comb begin
    unique case (half_sel_e'(half_i))
      HALF_LO: reg_sel = {{(DATA_W-HALF_W){1'b0}}, val_i[HALF_W-1:0]};
      HALF_HI: reg_sel = {{(DATA_W-HALF_W){1'b0}}, val_i[DATA_W-1:HALF_W]};
      default: reg_sel = val_i;
    endcase
  end

  generate
    if (HAS_IMM) begin : g_imm
      logic [DATA_W-1:0] imm_ext;
      assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
      assign src_sel = imm_sel_i ? imm_ext : reg_sel;
    end else begin : g_no_imm
      logic unused_imm;
      assign unused_imm = ^{imm_sel_i, imm_i};
      assign src_sel    = reg_sel;
    end
  endgenerate

  // two's complement: invert then add the negate bit
  assign op_o = (src_sel ^ {DATA_W{neg_i}}) + DATA_W'(neg_i);

endmodule

// File: rtl/tri_add_pair.sv
module tri_add_pair
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] mid_o
);
  localparam int SHIFT = DATA_W / 2;

  logic [DATA_W:0] pair_sum;

  // keep the pair carry for the right-shift mode
  assign pair_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    unique case (sum_mode_e'(mode_i))
      MODE_RSH: mid_o = DATA_W'(pair_sum >> SHIFT);
      MODE_LSH: mid_o = pair_sum[DATA_W-1:0] << SHIFT;
      default:  mid_o = pair_sum[DATA_W-1:0];
    endcase
  end

endmodule

// File: rtl/tri_add_final.sv
module tri_add_final
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] mid_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  logic [DATA_W:0] wide_sum;

  assign wide_sum = {1'b0, mid_i} + {1'b0, c_i} + {{DATA_W{1'b0}}, cin_i};
  assign res_o    = wide_sum[DATA_W-1:0];

  always_comb begin
    flags_o.zero  = (wide_sum[DATA_W-1:0] == '0);
    flags_o.sign  = wide_sum[DATA_W-1];
    flags_o.carry = wide_sum[DATA_W];
    flags_o.ovf   = (mid_i[DATA_W-1] == c_i[DATA_W-1]) &&
                    (wide_sum[DATA_W-1] != mid_i[DATA_W-1]);
  end

endmodule

// File: rtl/tri_add_unit.sv
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [1:0]        a_half_i,
  input  logic              a_neg_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        b_half_i,
  input  logic              b_neg_i,
  input  logic              b_imm_sel_i,
  input  logic [IMM_W-1:0]  b_imm_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [1:0]        c_half_i,
  input  logic              c_neg_i,
  input  logic              ext_i,
  input  logic              cc_i,
  output logic [DATA_W-1:0] res_o,
  output logic              valid_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic              carry_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] op_a, op_b, op_c, mid, res_d;
  logic [DATA_W-1:0] res_q;
  flags_t            flags_d, flags_q;
  logic              valid_q;
  logic              cin;

  tri_add_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .HAS_IMM(1'b0)) opsel_a_i (
    .val_i(a_i), .half_i(a_half_i), .neg_i(a_neg_i),
    .imm_sel_i(1'b0), .imm_i('0), .op_o(op_a)
  );

  tri_add_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .HAS_IMM(1'b1)) opsel_b_i (
    .val_i(b_i), .half_i(b_half_i), .neg_i(b_neg_i),
    .imm_sel_i(b_imm_sel_i), .imm_i(b_imm_i), .op_o(op_b)
  );

  tri_add_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .HAS_IMM(1'b0)) opsel_c_i (
    .val_i(c_i), .half_i(c_half_i), .neg_i(c_neg_i),
    .imm_sel_i(1'b0), .imm_i('0), .op_o(op_c)
  );

  tri_add_pair #(.DATA_W(DATA_W)) pair_i (
    .a_i(op_a), .b_i(op_b), .mode_i(mode_i), .mid_o(mid)
  );

  assign cin = ext_i & flags_q.carry;

  tri_add_final #(.DATA_W(DATA_W)) final_i (
    .mid_i(mid), .c_i(op_c), .cin_i(cin), .res_o(res_d), .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
      if (valid_i && cc_i) flags_q <= flags_d;
    end
  end

  assign res_o   = res_q;
  assign valid_o = valid_q;
  assign zero_o  = flags_q.zero;
  assign sign_o  = flags_q.sign;
  assign carry_o = flags_q.carry;
  assign ovf_o   = flags_q.ovf;

endmodule

// File: rtl/tri_add_chk.sv
module tri_add_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] c_i,
  input logic [1:0]        c_half_i,
  input logic              c_neg_i,
  input logic              ext_i,
  input logic              cc_i,
  input logic [DATA_W-1:0] res_o,
  input logic              valid_o,
  input logic              zero_o,
  input logic              sign_o,
  input logic              carry_o,
  input logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;

  a_r10_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r10_res_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  a_r9_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && cc_i) |=> $stable({zero_o, sign_o, carry_o, ovf_o}));
  a_r8_zero_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cc_i) |=> (zero_o == (res_o == '0)));
  a_r8_sign_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cc_i) |=> (sign_o == res_o[DATA_W-1]));
  a_r3_low_is_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b10 && !ext_i && c_half_i == 2'b01 && !c_neg_i)
      |=> (res_o[HALF_W-1:0] == $past(c_i[HALF_W-1:0])));
  a_r2_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b01 && !ext_i && c_i == '0)
      |=> (res_o[DATA_W-1:HALF_W+1] == '0));

endmodule

bind tri_add_unit tri_add_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
  .c_i(c_i), .c_half_i(c_half_i), .c_neg_i(c_neg_i), .ext_i(ext_i),
  .cc_i(cc_i), .res_o(res_o), .valid_o(valid_o), .zero_o(zero_o),
  .sign_o(sign_o), .carry_o(carry_o), .ovf_o(ovf_o)
);

// File: tb/tri_add_unit_tb_top.sv
`timescale 1ns/1ps
module tri_add_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic [1:0]  a_half_i = '0, b_half_i = '0, c_half_i = '0;
  logic        a_neg_i = 1'b0, b_neg_i = 1'b0, c_neg_i = 1'b0;
  logic        b_imm_sel_i = 1'b0;
  logic [19:0] b_imm_i = '0;
  logic        ext_i = 1'b0, cc_i = 1'b0;
  logic [31:0] res_o;
  logic        valid_o, zero_o, sign_o, carry_o, ovf_o;

  int checks = 0;
  int errors = 0;
  logic [3:0]  m_flags = '0;   // {zero, sign, carry, ovf}
  logic [31:0] m_res = '0;

  always #2 clk_i = ~clk_i;

  tri_add_unit dut_i (.*);

  function automatic logic [31:0] prep(logic [31:0] v, logic [1:0] h, logic n);
    logic [31:0] s;
    s = (h == 2'd1) ? {16'h0, v[15:0]} : (h == 2'd2) ? {16'h0, v[31:16]} : v;
    return n ? (32'd0 - s) : s;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // call at a falling edge; returns at the next falling edge after checking
  task automatic txn(logic [1:0] md, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                     logic [2:0] neg, logic [1:0] ha, logic [1:0] hb, logic [1:0] hc,
                     logic isel, logic [19:0] imm, logic ext, logic cc, string tag);
    logic [31:0] pa, pb, pc, mid;
    logic [32:0] p33, w;
    logic [3:0]  f;
    mode_i = md; a_i = a; b_i = b; c_i = c;
    {a_neg_i, b_neg_i, c_neg_i} = neg;
    a_half_i = ha; b_half_i = hb; c_half_i = hc;
    b_imm_sel_i = isel; b_imm_i = imm; ext_i = ext; cc_i = cc; valid_i = 1'b1;
    pa = prep(a, ha, neg[2]);
    pb = isel ? prep({{12{imm[19]}}, imm}, 2'd0, neg[1]) : prep(b, hb, neg[1]);
    pc = prep(c, hc, neg[0]);
    p33 = {1'b0, pa} + {1'b0, pb};
    mid = (md == 2'd1) ? p33[32:16] : (md == 2'd2) ? {p33[15:0], 16'h0} : p33[31:0];
    w = {1'b0, mid} + {1'b0, pc} + {32'd0, ext & m_flags[1]};
    f = {w[31:0] == 0, w[31], w[32], (mid[31] == pc[31]) && (w[31] != mid[31])};
    @(negedge clk_i);
    m_res = w[31:0];
    if (cc) m_flags = f;
    chk(res_o === m_res, tag, res_o, m_res);
    chk(valid_o === 1'b1, "R10 valid", {31'd0, valid_o}, 32'd1);
    chk({zero_o, sign_o, carry_o, ovf_o} === m_flags, cc ? "R8 flags" : "R9 flags held",
        {28'd0, zero_o, sign_o, carry_o, ovf_o}, {28'd0, m_flags});
  endtask

  task automatic idle(logic cc);
    valid_i = 1'b0; cc_i = cc; a_i = 32'hdead_beef; c_i = 32'h1234_5678;
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R10 idle valid", {31'd0, valid_o}, 32'd0);
    chk(res_o === m_res, "R10 res held", res_o, m_res);
    chk({zero_o, sign_o, carry_o, ovf_o} === m_flags, "R9 idle flags",
        {28'd0, zero_o, sign_o, carry_o, ovf_o}, {28'd0, m_flags});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    chk({res_o, valid_o, zero_o, sign_o, carry_o, ovf_o} === '0, "R11 reset",
        res_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: pair carry kept in bit 16
    txn(2'd1, 32'hffff_ffff, 32'h1, 32'h0, 3'b000, 2'd0, 2'd0, 2'd0, 0, 20'h0, 0, 1, "R2 carry kept");
    // R3: shifted-out pair bits vanish
    txn(2'd2, 32'h0001_8000, 32'h8000, 32'h5, 3'b000, 2'd0, 2'd0, 2'd0, 0, 20'h0, 0, 1, "R3 truncation");
    // R4 and R5: high half selected, then negated
    txn(2'd0, 32'h1234_5678, 32'h0, 32'h0, 3'b100, 2'd2, 2'd0, 2'd0, 0, 20'h0, 0, 1, "R4 R5 hi then neg");
    txn(2'd0, 32'h1234_5678, 32'h0, 32'h0, 3'b000, 2'd1, 2'd0, 2'd0, 0, 20'h0, 0, 1, "R4 lo half");
    // R6: immediate sign-extended, B register and half ignored
    txn(2'd0, 32'h0, 32'hffff_ffff, 32'h0, 3'b000, 2'd0, 2'd2, 2'd0, 1, 20'h80000, 0, 1, "R6 imm neg");
    txn(2'd0, 32'h10, 32'h1234_5678, 32'h0, 3'b000, 2'd0, 2'd1, 2'd0, 1, 20'h7ffff, 0, 1, "R6 imm pos");
    // R7: carry chaining
    txn(2'd0, 32'hffff_ffff, 32'h0, 32'h1, 3'b000, 2'd0, 2'd0, 2'd0, 0, 20'h0, 0, 1, "R7 make carry");
    txn(2'd0, 32'h0, 32'h0, 32'h0, 3'b000, 2'd0, 2'd0, 2'd0, 0, 20'h0, 1, 0, "R7 ext uses carry");
    txn(2'd0, 32'h0, 32'h0, 32'h0, 3'b000, 2'd0, 2'd0, 2'd0, 0, 20'h0, 0, 0, "R7 no ext");
    // R8: signed overflow
    txn(2'd0, 32'h7fff_ffff, 32'h0, 32'h1, 3'b000, 2'd0, 2'd0, 2'd0, 0, 20'h0, 0, 1, "R8 overflow");
    idle(1'b1);
    idle(1'b0);

    for (int md = 0; md < 4; md++)
      for (int ng = 0; ng < 8; ng++)
        for (int ha = 0; ha < 4; ha++)
          for (int k = 0; k < 4; k++) begin
            logic [31:0] ra, rb, rc;
            ra = $urandom; rb = $urandom; rc = $urandom;
            if (k == 0) begin ra = 32'hffff_ffff; rb = 32'hffff_ffff; end
            txn(2'(md), ra, rb, rc, 3'(ng), 2'(ha), 2'(k), 2'((ha + k) % 4),
                1'(k == 2 && ng[0]), 20'($urandom), 1'(k == 3), 1'(k[0] | ng[1]),
                (md == 1) ? "R2 sweep" : (md == 2) ? "R3 sweep" : "R1 sweep");
          end
    idle(1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule